// File: doc/BRIEF.md
# 32-to-16-bit Host Write-Buffered Access Bridge

This block sits between a 32-bit host target port and a 16-bit terminal side that holds a 64K x 16 memory and a small 16-bit register file. The host sees two windows, chosen by a window-select input: one maps terminal memory as 32-bit words, the other maps registers. Every host write goes into a 32-entry write buffer that holds 32 data bits plus the window and address, so a burst of writes is taken at one word per clock while the slower terminal side drains it. A full 32-halfword message therefore costs the host sixteen 32-bit writes.

A memory-window word is split into two 16-bit terminal accesses: the low halfword at terminal address 2n first, then the high halfword at 2n+1. A register-window access is a single 16-bit access that carries the low half of the host data; on a register read the upper 16 bits returned to the host are zero. A host read waits until the write buffer is empty and the last buffered write has finished on the terminal side, so a read always observes every earlier write.

Top module: `hb16_bridge`

## Requirements
- R1: After reset `h_wready` is 1, `h_rvalid` is 0 and `t_req` is 0.
- R2: A memory-window write of word n with data D produces two terminal writes with `t_space`=0: first address 2n with D[15:0], then address 2n+1 with D[31:16].
- R3: A register-window write produces exactly one terminal write with `t_space`=1, address equal to the low 6 bits of `h_addr` (zero-extended), and data D[15:0].
- R4: The write buffer accepts 32 writes while the terminal side stalls; `h_wready` stays 1 after 31 buffered writes and is 0 with 32 buffered.
- R5: A write strobe while `h_wready` is 0 is ignored: it reaches neither the terminal side nor the memory.
- R6: A memory-window read of word n performs terminal reads at 2n and then 2n+1 and returns {data at 2n+1, data at 2n} on `h_rdata`.
- R7: A register-window read performs one terminal read and returns the 16-bit value in `h_rdata[15:0]` with `h_rdata[31:16]` = 0.
- R8: A read is not started on the terminal side until every earlier buffered write has completed there, and its result reflects those writes.
- R9: While `t_req` is 1 and `t_ack` is 0, `t_req`, `t_we`, `t_space`, `t_addr` and `t_wdata` hold their values into the next cycle.
- R10: Buffered writes reach the terminal side in the order the host issued them, across both windows.
- R11: `h_rvalid` is a single-cycle pulse per read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Synchronous active-low reset |
| h_wr | input | 1 | Host write strobe, taken on a clock edge where `h_wready` is 1 |
| h_rd | input | 1 | Host read request, held until `h_rvalid`, dropped the cycle after |
| h_win | input | 1 | Window select: 0 memory, 1 register |
| h_addr | input | 15 | Host word address (memory: 32-bit word index; register: low 6 bits used) |
| h_wdata | input | 32 | Host write data |
| h_wready | output | 1 | Write buffer has room |
| h_rvalid | output | 1 | One-cycle read-data-valid pulse |
| h_rdata | output | 32 | Read data returned to the host |
| t_req | output | 1 | Terminal access request, held until acknowledged |
| t_we | output | 1 | Terminal access is a write |
| t_space | output | 1 | Terminal target: 0 memory, 1 register |
| t_addr | output | 16 | Terminal halfword or register address |
| t_wdata | output | 16 | Terminal write data |
| t_ack | input | 1 | Terminal completes the current access this cycle |
| t_rdata | input | 16 | Terminal read data, valid with `t_ack` on reads |

## Verification
The embedded properties watch, cycle by cycle, that a stalled terminal request holds every field steady, that the high-halfword access follows the low one at the next address, that the buffer is never pushed when full nor popped when empty, that pops coincide with completed terminal writes, and that read-valid is a one-cycle pulse with a zero upper half on register reads. What only the scenarios can show is end-to-end data: that the halves land at the right addresses with the right data, that the buffer holds exactly 32 words and drops a write offered while full, that order survives a mixed burst under an intermittent acknowledge, and that a read issued behind pending writes returns their values.

// File: rtl/hb16_pkg.sv
// Package hb16_pkg
// Shared widths and types for the 32-to-16-bit host bridge.
// Assumes the terminal memory is addressed in 16-bit halfwords and the
// host addresses it in 32-bit words, so the host address is one bit narrower.
package hb16_pkg;

    parameter int unsigned TGT_AW  = 16;            // terminal halfword address width (64K)
    parameter int unsigned TGT_DW  = 16;            // terminal data width
    parameter int unsigned HOST_DW = 2 * TGT_DW;    // host data width
    parameter int unsigned HOST_AW = TGT_AW - 1;    // host word address width

    // One buffered host write
    typedef struct packed {
        logic               win;    // 0 memory window, 1 register window
        logic [HOST_AW-1:0] addr;
        logic [HOST_DW-1:0] data;
    } wr_entry_t;

    // Terminal-side sequencer states
    typedef enum logic [2:0] {
        S_IDLE,
        S_WLO,
        S_WHI,
        S_RLO,
        S_RHI,
        S_RESP
    } seq_state_t;

endpackage

// File: rtl/hb16_wfifo.sv
// Module hb16_wfifo
// Show-ahead write buffer: the head entry is visible on rdata whenever the
// buffer is not empty. Any depth is allowed; pointers wrap explicitly.
// Assumes the caller never pushes when full nor pops when empty (checked).
module hb16_wfifo #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             full,
    output logic             empty
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] store [DEPTH];
    logic [PW-1:0]    wp;
    logic [PW-1:0]    rp;
    logic [CW-1:0]    cnt;

    // Storage write; data needs no reset
    always_ff @(posedge clk) begin
        if (push) begin
            store[wp] <= wdata;
        end
    end

    // Pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) begin
                wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            end
            if (pop) begin
                rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            end
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // Head and status flags
    always_comb begin
        rdata = store[rp];
        full  = (cnt == CW'(DEPTH));
        empty = (cnt == '0);
    end

    // R4: the caller must respect the full flag
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full)
        else $error("write buffer pushed while full");

    // R4: pops only from a non-empty buffer
    p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty)
        else $error("write buffer popped while empty");

endmodule

// File: rtl/hb16_seq.sv
// Module hb16_seq
// Terminal-side sequencer. Drains the write buffer first (oldest entry at the
// head), turning each memory word into a low then high halfword access and
// each register entry into one access. A host read is started only from idle
// with the buffer empty, so it follows every earlier write.
// Assumes the host holds h_rd until h_rvalid and does not write meanwhile.
module hb16_seq
    import hb16_pkg::*;
#(
    parameter int REG_AW = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  wr_entry_t          head,
    input  logic               fifo_empty,
    output logic               fifo_pop,
    input  logic               h_rd,
    input  logic               h_win,
    input  logic [HOST_AW-1:0] h_addr,
    output logic               h_rvalid,
    output logic [HOST_DW-1:0] h_rdata,
    output logic               t_req,
    output logic               t_we,
    output logic               t_space,
    output logic [TGT_AW-1:0]  t_addr,
    output logic [TGT_DW-1:0]  t_wdata,
    input  logic               t_ack,
    input  logic [TGT_DW-1:0]  t_rdata
);

    seq_state_t         state;
    logic               rd_win;
    logic [HOST_AW-1:0] rd_addr;
    logic [HOST_DW-1:0] rd_data;

    // Maps a host window/address/half to a terminal address
    function automatic logic [TGT_AW-1:0] map_addr(input logic win,
                                                    input logic [HOST_AW-1:0] a,
                                                    input logic hi);
        if (win) begin
            return TGT_AW'(a[REG_AW-1:0]);
        end
        return {a, hi};
    endfunction

    // State, read-request capture and read-data assembly
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            rd_win  <= 1'b0;
            rd_addr <= '0;
            rd_data <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (!fifo_empty) begin
                        state <= S_WLO;
                    end else if (h_rd) begin
                        rd_win  <= h_win;
                        rd_addr <= h_addr;
                        state   <= S_RLO;
                    end
                end
                S_WLO: if (t_ack) state <= head.win ? S_IDLE : S_WHI;
                S_WHI: if (t_ack) state <= S_IDLE;
                S_RLO: begin
                    if (t_ack) begin
                        rd_data <= {{TGT_DW{1'b0}}, t_rdata};
                        state   <= rd_win ? S_RESP : S_RHI;
                    end
                end
                S_RHI: begin
                    if (t_ack) begin
                        rd_data[HOST_DW-1:TGT_DW] <= t_rdata;
                        state <= S_RESP;
                    end
                end
                S_RESP:  state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // Terminal request fields decoded from the state
    always_comb begin
        t_req   = 1'b0;
        t_we    = 1'b0;
        t_space = 1'b0;
        t_addr  = '0;
        t_wdata = '0;
        case (state)
            S_WLO: begin
                t_req   = 1'b1;
                t_we    = 1'b1;
                t_space = head.win;
                t_addr  = map_addr(head.win, head.addr, 1'b0);
                t_wdata = head.data[TGT_DW-1:0];
            end
            S_WHI: begin
                t_req   = 1'b1;
                t_we    = 1'b1;
                t_addr  = map_addr(1'b0, head.addr, 1'b1);
                t_wdata = head.data[HOST_DW-1:TGT_DW];
            end
            S_RLO: begin
                t_req   = 1'b1;
                t_space = rd_win;
                t_addr  = map_addr(rd_win, rd_addr, 1'b0);
            end
            S_RHI: begin
                t_req   = 1'b1;
                t_addr  = map_addr(1'b0, rd_addr, 1'b1);
            end
            default: ;
        endcase
    end

    // Retire the head entry when its last access completes
    always_comb begin
        fifo_pop = t_ack && ((state == S_WLO && head.win) || state == S_WHI);
    end

    // Host read response
    always_comb begin
        h_rvalid = (state == S_RESP);
        h_rdata  = rd_data;
    end

    // R9: a stalled request keeps every field
    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (t_req && !t_ack) |=> (t_req && $stable(t_we) && $stable(t_space)
                               && $stable(t_addr) && $stable(t_wdata)))
        else $error("terminal request changed before acknowledge");

    // R2 / R6: a completed low memory halfword is followed by the high one
    p_pair_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (t_req && t_ack && !t_space && !t_addr[0])
            |=> (t_req && !t_space && t_addr == $past(t_addr) + 1'b1))
        else $error("high halfword did not follow low halfword");

    // R10: the buffer retires only on a completed terminal write
    p_pop_on_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> (t_req && t_ack && t_we))
        else $error("buffer entry retired without a terminal write");

    // R11: read-valid lasts one cycle
    p_rvalid_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        h_rvalid |=> !h_rvalid)
        else $error("read-valid longer than one cycle");

    // R7: register reads carry a zero upper half
    p_reg_hi_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (h_rvalid && rd_win) |-> (h_rdata[HOST_DW-1:TGT_DW] == '0))
        else $error("register read returned non-zero upper half");

endmodule

// File: rtl/hb16_bridge.sv
// Module hb16_bridge
// Top of the 32-to-16-bit host bridge: the host write port feeds the write
// buffer; the sequencer drains it to the terminal side and serves reads.
// Assumes one clock for host and terminal sides and a well-behaved host
// (read held until valid, no write while a read is pending).
module hb16_bridge
    import hb16_pkg::*;
#(
    parameter int FIFO_DEPTH = 32,
    parameter int REG_AW     = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               h_wr,
    input  logic               h_rd,
    input  logic               h_win,
    input  logic [HOST_AW-1:0] h_addr,
    input  logic [HOST_DW-1:0] h_wdata,
    output logic               h_wready,
    output logic               h_rvalid,
    output logic [HOST_DW-1:0] h_rdata,
    output logic               t_req,
    output logic               t_we,
    output logic               t_space,
    output logic [TGT_AW-1:0]  t_addr,
    output logic [TGT_DW-1:0]  t_wdata,
    input  logic               t_ack,
    input  logic [TGT_DW-1:0]  t_rdata
);

    localparam int ENT_W = $bits(wr_entry_t);

    wr_entry_t        in_ent;
    wr_entry_t        head_ent;
    logic [ENT_W-1:0] head_vec;
    logic             fifo_full;
    logic             fifo_empty;
    logic             fifo_push;
    logic             fifo_pop;

    // Host write acceptance
    always_comb begin
        in_ent    = '{win: h_win, addr: h_addr, data: h_wdata};
        h_wready  = !fifo_full;
        fifo_push = h_wr && !fifo_full;
        head_ent  = wr_entry_t'(head_vec);
    end

    hb16_wfifo #(
        .DEPTH (FIFO_DEPTH),
        .WIDTH (ENT_W)
    ) u_wfifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (fifo_push),
        .wdata (in_ent),
        .pop   (fifo_pop),
        .rdata (head_vec),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    hb16_seq #(
        .REG_AW (REG_AW)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .head       (head_ent),
        .fifo_empty (fifo_empty),
        .fifo_pop   (fifo_pop),
        .h_rd       (h_rd),
        .h_win      (h_win),
        .h_addr     (h_addr),
        .h_rvalid   (h_rvalid),
        .h_rdata    (h_rdata),
        .t_req      (t_req),
        .t_we       (t_we),
        .t_space    (t_space),
        .t_addr     (t_addr),
        .t_wdata    (t_wdata),
        .t_ack      (t_ack),
        .t_rdata    (t_rdata)
    );

    // R5: a write offered while full leaves the buffer full
    p_full_ignores_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && !fifo_pop) |=> fifo_full)
        else $error("buffer left full state without a pop");

endmodule

// File: tb/sim_hb16_bridge.sv
// Scoreboard bench: driver tasks queue expected terminal accesses and read
// results; monitor processes pop and compare them as the design produces them.
module sim_hb16_bridge;
    import hb16_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 32;
    localparam int RAW        = 6;
    localparam int MEM_N      = 1024;
    localparam int REG_N      = 1 << RAW;

    typedef struct {
        bit    we;
        bit    space;
        int    addr;
        int    data;
        string tag;
    } txn_t;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               h_wr = 1'b0;
    logic               h_rd = 1'b0;
    logic               h_win = 1'b0;
    logic [HOST_AW-1:0] h_addr = '0;
    logic [HOST_DW-1:0] h_wdata = '0;
    logic               h_wready;
    logic               h_rvalid;
    logic [HOST_DW-1:0] h_rdata;
    logic               t_req;
    logic               t_we;
    logic               t_space;
    logic [TGT_AW-1:0]  t_addr;
    logic [TGT_DW-1:0]  t_wdata;
    logic               t_ack;
    logic [TGT_DW-1:0]  t_rdata;

    logic               hold_ack = 1'b1;
    logic               slow = 1'b0;
    int                 cyc = 0;

    logic [15:0] tmem [MEM_N];
    logic [15:0] treg [REG_N];
    logic [15:0] smem [MEM_N];
    logic [15:0] sreg [REG_N];

    txn_t        exp_t [$];
    logic [31:0] exp_rd [$];
    string       exp_rtag [$];

    int vectors = 0;
    int errors  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    hb16_bridge #(.FIFO_DEPTH(DEPTH), .REG_AW(RAW)) u0 (
        .clk(clk), .rst_n(rst_n), .h_wr(h_wr), .h_rd(h_rd), .h_win(h_win),
        .h_addr(h_addr), .h_wdata(h_wdata), .h_wready(h_wready),
        .h_rvalid(h_rvalid), .h_rdata(h_rdata), .t_req(t_req), .t_we(t_we),
        .t_space(t_space), .t_addr(t_addr), .t_wdata(t_wdata),
        .t_ack(t_ack), .t_rdata(t_rdata)
    );

    // Terminal model: acknowledge pattern, read data and memory update
    always @(posedge clk) cyc <= cyc + 1;
    assign t_ack = !hold_ack && (!slow || cyc[0]);
    always_comb t_rdata = t_space ? treg[t_addr[RAW-1:0]] : tmem[t_addr[9:0]];
    always @(posedge clk) begin
        if (rst_n && t_req && t_ack && t_we) begin
            if (t_space) treg[t_addr[RAW-1:0]] <= t_wdata;
            else         tmem[t_addr[9:0]]     <= t_wdata;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    // Monitor: terminal accesses against the expected queue, plus R9 hold check
    logic        pend = 1'b0;
    logic [31:0] pend_sig;
    always @(negedge clk) begin
        if (rst_n) begin
            if (pend) begin
                chk(t_req && {t_we, t_space, t_addr, t_wdata[12:0]} == pend_sig,
                    "R9", "stalled request changed",
                    {t_we, t_space, t_addr, t_wdata[12:0]}, pend_sig);
            end
            pend     = t_req && !t_ack;
            pend_sig = {t_we, t_space, t_addr, t_wdata[12:0]};
            if (t_req && t_ack) begin
                if (exp_t.size() == 0) begin
                    chk(1'b0, "R5/R10", "unexpected terminal access",
                        {t_we, t_space, 14'(0), t_addr}, 32'h0);
                end else begin
                    txn_t e;
                    e = exp_t.pop_front();
                    chk(t_we == e.we && t_space == e.space && int'(t_addr) == e.addr,
                        e.tag, "terminal access kind/address",
                        {t_we, t_space, 14'(0), t_addr},
                        {e.we, e.space, 14'(0), 16'(e.addr)});
                    if (e.we) begin
                        chk(int'(t_wdata) == e.data, e.tag, "terminal write data",
                            32'(t_wdata), 32'(e.data));
                    end
                end
            end
            if (h_rvalid) begin
                if (exp_rd.size() == 0) begin
                    chk(1'b0, "R11", "unexpected read-valid", h_rdata, 32'h0);
                end else begin
                    logic [31:0] ev;
                    string       tg;
                    ev = exp_rd.pop_front();
                    tg = exp_rtag.pop_front();
                    chk(h_rdata == ev, tg, "read data", h_rdata, ev);
                end
            end
        end
    end

    // Driver: one host write; expectations follow R2 (mem) and R3 (reg)
    task automatic hwrite(input bit win, input int addr, input logic [31:0] d,
                          input string tag);
        if (win) begin
            exp_t.push_back('{1'b1, 1'b1, addr % REG_N, int'(d[15:0]), tag});
            sreg[addr % REG_N] = d[15:0];
        end else begin
            exp_t.push_back('{1'b1, 1'b0, 2 * addr, int'(d[15:0]), tag});
            exp_t.push_back('{1'b1, 1'b0, 2 * addr + 1, int'(d[31:16]), tag});
            smem[2 * addr]     = d[15:0];
            smem[2 * addr + 1] = d[31:16];
        end
        h_wr    = 1'b1;
        h_win   = win;
        h_addr  = HOST_AW'(addr);
        h_wdata = d;
        while (!h_wready) @(negedge clk);
        @(negedge clk);
        h_wr = 1'b0;
    endtask

    // Driver: one host read; expectations follow R6 (mem) and R7 (reg)
    task automatic hread(input bit win, input int addr, input string tag);
        if (win) begin
            exp_t.push_back('{1'b0, 1'b1, addr % REG_N, 0, tag});
            exp_rd.push_back({16'h0, sreg[addr % REG_N]});
        end else begin
            exp_t.push_back('{1'b0, 1'b0, 2 * addr, 0, tag});
            exp_t.push_back('{1'b0, 1'b0, 2 * addr + 1, 0, tag});
            exp_rd.push_back({smem[2 * addr + 1], smem[2 * addr]});
        end
        exp_rtag.push_back(tag);
        h_rd   = 1'b1;
        h_win  = win;
        h_addr = HOST_AW'(addr);
        do @(negedge clk); while (!h_rvalid);
        h_rd = 1'b0;
        @(negedge clk);
        chk(!h_rvalid, "R11", "read-valid not a single pulse", 32'(h_rvalid), 32'h0);
    endtask

    task automatic drain();
        while (exp_t.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    endtask

    // Watchdog
    initial begin
        repeat (60000) @(posedge clk);
        vectors++;
        errors++;
        $display("FAIL watchdog (all requirements): actual hung expected finished");
        summary();
        $finish;
    end

    // Stimulus
    initial begin
        for (int i = 0; i < MEM_N; i++) begin
            tmem[i] = 16'(i * 37 + 11);
            smem[i] = tmem[i];
        end
        for (int i = 0; i < REG_N; i++) begin
            treg[i] = 16'(i * 91 + 3);
            sreg[i] = treg[i];
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(h_wready == 1'b1, "R1", "wready after reset", 32'(h_wready), 32'h1);
        chk(h_rvalid == 1'b0, "R1", "rvalid after reset", 32'(h_rvalid), 32'h0);
        chk(t_req == 1'b0, "R1", "t_req after reset", 32'(t_req), 32'h0);
        hold_ack = 1'b0;

        // R2 / R6: memory word split and readback
        hwrite(1'b0, 5, 32'hA1B2_C3D4, "R2");
        drain();
        hread(1'b0, 5, "R6");
        hread(1'b0, 100, "R6");
        hread(1'b0, 511, "R6");

        // R3 / R7: register window, including the top register
        hwrite(1'b1, 7, 32'hDEAD_1234, "R3");
        hwrite(1'b1, 63 + 64 * 5, 32'hFFFF_5A5A, "R3");
        drain();
        hread(1'b1, 7, "R7");
        hread(1'b1, 63, "R7");
        hread(1'b1, 12, "R7");

        // R10: mixed burst (a 32-halfword message) under intermittent acknowledge
        slow = 1'b1;
        for (int i = 0; i < 16; i++) begin
            hwrite(1'b0, 200 + i, {16'(i * 7 + 1), 16'(i * 13 + 2)}, "R10");
            if (i == 8) hwrite(1'b1, 30, 32'h0000_BEEF, "R10");
        end
        drain();
        hread(1'b0, 200, "R10");
        hread(1'b0, 215, "R10");
        hread(1'b1, 30, "R10");
        slow = 1'b0;

        // R4 / R5: fill the buffer with the terminal stalled
        hold_ack = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            hwrite(1'b0, 300 + i, {16'(i + 16'h100), 16'(i + 16'h200)}, "R4");
            if (i == DEPTH - 2) begin
                chk(h_wready == 1'b1, "R4", "wready with 31 buffered", 32'(h_wready), 32'h1);
            end
        end
        chk(h_wready == 1'b0, "R4", "wready with 32 buffered", 32'(h_wready), 32'h0);
        h_wr    = 1'b1;
        h_win   = 1'b0;
        h_addr  = HOST_AW'(400);
        h_wdata = 32'h7777_7777;
        repeat (4) begin
            @(negedge clk);
            chk(h_wready == 1'b0, "R5", "wready while full", 32'(h_wready), 32'h0);
        end
        h_wr = 1'b0;
        hold_ack = 1'b0;
        drain();
        hread(1'b0, 400, "R5");
        hread(1'b0, 331, "R4");

        // R8: read issued behind pending writes
        hold_ack = 1'b1;
        hwrite(1'b0, 500, 32'h1357_9BDF, "R8");
        hwrite(1'b1, 20, 32'h0000_2468, "R8");
        fork
            begin
                repeat (10) @(negedge clk);
                hold_ack = 1'b0;
            end
        join_none
        hread(1'b0, 500, "R8");
        hread(1'b1, 20, "R8");

        drain();
        chk(exp_t.size() == 0, "R10", "pending expected accesses", 32'(exp_t.size()), 32'h0);
        summary();
        $finish;
    end

endmodule